// File: doc/BRIEF.md
# Two-Level Branch Target Buffer

This block caches the targets of taken branches for an instruction fetch unit. Every fetch address is searched in a small fully associative first level. An address that misses there is looked up in a larger direct-mapped second level. The two levels answer at different times, and the fetch unit sizes its redirect bubble from the channel that answers: one cycle for a first-level hit, two cycles for a second-level hit. A second-level hit is copied into the first level, so the next lookup of that branch gets the short bubble.

Training comes from branch resolution, which supplies the branch address, its target and whether it was taken. A taken branch is written into both levels. A not-taken branch that is held in the first level is removed from it. A flush input empties both levels in a single cycle. Direction prediction, indirect targets and return addresses belong to other blocks.

Top module: `btb2l`

## Requirements
- R1: After reset both levels are empty: no result output is active, and a lookup of any address reports a miss two cycles after it is presented.
- R2: A lookup presented in cycle T that hits the first level drives `l1_hit` high with the stored target on `l1_target` in cycle T+1, and that lookup produces no second-level result.
- R3: A lookup in cycle T that misses the first level and hits the second level drives `l2_hit` high with the stored target on `l2_target` in cycle T+2, and `l1_hit` stays low in cycle T+1.
- R4: A lookup in cycle T that misses both levels drives `lk_miss` high in cycle T+2; `l2_hit` and `lk_miss` are never high together.
- R5: A resolved taken branch (`upd_valid` high, `upd_taken` = 1) writes its address and target into both levels; a later lookup of that address hits the first level.
- R6: A second-level hit is copied into the first level, so a lookup of the same address two or more cycles after the second-level result hits the first level.
- R7: A resolved not-taken branch (`upd_taken` = 0) removes a matching first-level entry and leaves the second level unchanged; a later lookup of that address is answered by the second level.
- R8: The first level replaces entries in round-robin order starting from slot 0 after reset or flush; with 64 entries, the 65th distinct taken branch evicts the first one written, while the second and the 65th still hit the first level.
- R9: When a lookup and an update fall on the same second-level index (address bits [IDX_W+1:2]) in the same cycle, the update is applied and the lookup gives no first-level hit and reports a miss two cycles later.
- R10: A flush clears every valid bit of both levels in one cycle and cancels results in flight; the cycle after a flush no result output is active and earlier entries miss.
- R11: A taken update of an address already held in the first level overwrites its target in place, and the next lookup returns the new target.
- R12: The second level is direct-mapped on address bits [IDX_W+1:2] (bits [12:2] with 2048 entries) with a tag from the bits above; two branches sharing those index bits evict each other from the second level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate both levels and drop results in flight |
| lk_valid | input | 1 | Fetch lookup request |
| lk_pc | input | 32 | Fetch address to look up |
| upd_valid | input | 1 | Branch resolution update |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_target | input | 32 | Target of the resolved branch |
| upd_taken | input | 1 | 1 = branch was taken, 0 = not taken |
| l1_hit | output | 1 | First-level hit, one cycle after the lookup |
| l1_target | output | 32 | Target from the first level |
| l2_hit | output | 1 | Second-level hit, two cycles after the lookup |
| l2_target | output | 32 | Target from the second level |
| lk_miss | output | 1 | Lookup missed both levels, two cycles after the lookup |

## Verification
Lookups are tried against addresses never written, addresses trained as taken, addresses trained twice with different targets, and addresses dropped from the first level by a not-taken update, which separates first-level hits, second-level hits with promotion, and double misses by the cycle in which each answer appears. A pair of branches sharing second-level index bits distinguishes direct-mapped eviction from tag matching. A lookup colliding with an update on the same index, a flush, and a run of 65 distinct taken branches tell the collision priority, the single-cycle clear and the round-robin victim order apart from ordinary hits.

// File: rtl/btb2l_pkg.sv
package btb2l_pkg;
  parameter int PC_W = 32;

  typedef logic [PC_W-1:0] pc_t;

  // One write request into the first level.
  typedef struct packed {
    logic en;
    logic insert;   // 1: install or refresh, 0: invalidate a match
    pc_t  pc;
    pc_t  target;
  } l1_wr_t;
endpackage

// File: rtl/btb_l1_cam.sv
module btb_l1_cam
  import btb2l_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int TAG_W   = 20
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   flush,
  input  pc_t    lk_pc,
  output logic   lk_hit,
  output pc_t    lk_target,
  input  l1_wr_t wr
);
  localparam int PTR_W = $clog2(ENTRIES);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  function automatic logic [TAG_W-1:0] tag_of(input pc_t pc);
    return pc[2 +: TAG_W];
  endfunction

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  pc_t                tgt_q [ENTRIES];
  logic [PTR_W-1:0]   rr_q;

  logic [ENTRIES-1:0] lk_match;
  logic [ENTRIES-1:0] wr_match;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign lk_match[i] = valid_q[i] && (tag_q[i] == tag_of(lk_pc));
    assign wr_match[i] = valid_q[i] && (tag_q[i] == tag_of(wr.pc));
  end

  logic             wr_hit;
  logic [PTR_W-1:0] wr_idx;
  logic [PTR_W-1:0] slot;

  always_comb begin
    lk_hit    = |lk_match;
    lk_target = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) lk_target = lk_target | tgt_q[i];
    end
  end

  always_comb begin
    wr_hit = |wr_match;
    wr_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (wr_match[i]) wr_idx = PTR_W'(i);
    end
    slot = wr_hit ? wr_idx : rr_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else if (wr.en) begin
      if (wr.insert) begin
        valid_q[slot] <= 1'b1;
        if (!wr_hit) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
      end else if (wr_hit) begin
        valid_q[wr_idx] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr.en && wr.insert && !flush) begin
      tag_q[slot] <= tag_of(wr.pc);
      tgt_q[slot] <= wr.target;
    end
  end
endmodule

// File: rtl/btb_l2_ram.sv
module btb_l2_ram
  import btb2l_pkg::*;
#(
  parameter int ENTRIES = 2048,
  parameter int TAG_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output pc_t              rd_target,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  pc_t              wr_target
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_mem [ENTRIES];
  pc_t                tgt_mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      valid_q  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= valid_q[rd_idx];
      if (wr_en) valid_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    rd_tag    <= tag_mem[rd_idx];
    rd_target <= tgt_mem[rd_idx];
    if (wr_en && !flush) begin
      tag_mem[wr_idx] <= wr_tag;
      tgt_mem[wr_idx] <= wr_target;
    end
  end
endmodule

// File: rtl/btb2l.sv
module btb2l
  import btb2l_pkg::*;
#(
  parameter int L1_ENTRIES = 64,
  parameter int L2_ENTRIES = 2048,
  parameter int L1_TAG_W   = 20,
  parameter int L2_TAG_W   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flush,
  input  logic        lk_valid,
  input  logic [31:0] lk_pc,
  input  logic        upd_valid,
  input  logic [31:0] upd_pc,
  input  logic [31:0] upd_target,
  input  logic        upd_taken,
  output logic        l1_hit,
  output logic [31:0] l1_target,
  output logic        l2_hit,
  output logic [31:0] l2_target,
  output logic        lk_miss
);
  localparam int IDX_W = $clog2(L2_ENTRIES);

  function automatic logic [IDX_W-1:0] idx_of(input pc_t pc);
    return pc[2 +: IDX_W];
  endfunction

  function automatic logic [L2_TAG_W-1:0] l2tag_of(input pc_t pc);
    return pc[2 + IDX_W +: L2_TAG_W];
  endfunction

  // Named internal events
  logic conflict;
  logic l1_lk_hit;
  pc_t  l1_lk_tgt;
  logic l2_match;
  logic promote_fire;

  logic             l2_rd_valid;
  logic [L2_TAG_W-1:0] l2_rd_tag;
  pc_t              l2_rd_tgt;

  // Pipeline state
  logic f1_hit_q;
  pc_t  f1_tgt_q;
  logic p1_valid_q, p1_kill_q;
  pc_t  p1_pc_q;
  logic f2_valid_q, f2_hit_q;
  pc_t  f2_tgt_q;

  assign conflict = lk_valid && upd_valid && (idx_of(lk_pc) == idx_of(upd_pc));

  l1_wr_t l1_wr;
  always_comb begin
    l1_wr.en     = upd_valid || promote_fire;
    l1_wr.insert = upd_valid ? upd_taken  : 1'b1;
    l1_wr.pc     = upd_valid ? upd_pc     : p1_pc_q;
    l1_wr.target = upd_valid ? upd_target : l2_rd_tgt;
  end

  btb_l1_cam #(
    .ENTRIES(L1_ENTRIES),
    .TAG_W  (L1_TAG_W)
  ) u_l1 (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .lk_pc    (lk_pc),
    .lk_hit   (l1_lk_hit),
    .lk_target(l1_lk_tgt),
    .wr       (l1_wr)
  );

  btb_l2_ram #(
    .ENTRIES(L2_ENTRIES),
    .TAG_W  (L2_TAG_W)
  ) u_l2 (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .rd_idx   (idx_of(lk_pc)),
    .rd_valid (l2_rd_valid),
    .rd_tag   (l2_rd_tag),
    .rd_target(l2_rd_tgt),
    .wr_en    (upd_valid && upd_taken),
    .wr_idx   (idx_of(upd_pc)),
    .wr_tag   (l2tag_of(upd_pc)),
    .wr_target(upd_target)
  );

  assign l2_match     = p1_valid_q && !p1_kill_q && l2_rd_valid &&
                        (l2_rd_tag == l2tag_of(p1_pc_q));
  assign promote_fire = l2_match && !upd_valid && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      f1_hit_q   <= 1'b0;
      p1_valid_q <= 1'b0;
      p1_kill_q  <= 1'b0;
      f2_valid_q <= 1'b0;
      f2_hit_q   <= 1'b0;
    end else begin
      f1_hit_q   <= lk_valid && l1_lk_hit && !conflict;
      p1_valid_q <= lk_valid && (!l1_lk_hit || conflict);
      p1_kill_q  <= conflict;
      f2_valid_q <= p1_valid_q;
      f2_hit_q   <= l2_match;
    end
  end

  always_ff @(posedge clk) begin
    f1_tgt_q <= l1_lk_tgt;
    p1_pc_q  <= lk_pc;
    f2_tgt_q <= l2_rd_tgt;
  end

  assign l1_hit    = f1_hit_q;
  assign l1_target = f1_tgt_q;
  assign l2_hit    = f2_valid_q && f2_hit_q;
  assign l2_target = f2_tgt_q;
  assign lk_miss   = f2_valid_q && !f2_hit_q;
endmodule

// File: rtl/btb2l_checker.sv
module btb2l_checker #(
  parameter int IDX_W = 11
) (
  input logic        clk,
  input logic        rst_n,
  input logic        flush,
  input logic        lk_valid,
  input logic [31:0] lk_pc,
  input logic        upd_valid,
  input logic [31:0] upd_pc,
  input logic        l1_hit,
  input logic        l2_hit,
  input logic        lk_miss,
  input logic        promote_fire
);
  logic same_idx;
  assign same_idx = lk_valid && upd_valid && !flush &&
                    (lk_pc[2 +: IDX_W] == upd_pc[2 +: IDX_W]);

  a_r2_l1_after_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    l1_hit |-> $past(lk_valid));

  a_r3_l2_after_two: assert property (@(posedge clk) disable iff (!rst_n)
    (l2_hit || lk_miss) |-> $past(lk_valid, 2));

  a_r4_outcome_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(l2_hit && lk_miss));

  a_r6_promote_reported: assert property (@(posedge clk) disable iff (!rst_n)
    promote_fire |=> l2_hit);

  a_r9_conflict_no_l1: assert property (@(posedge clk) disable iff (!rst_n)
    same_idx |=> !l1_hit);

  a_r9_conflict_miss: assert property (@(posedge clk) disable iff (!rst_n)
    same_idx ##1 !flush |=> lk_miss);

  a_r10_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!l1_hit && !l2_hit && !lk_miss));
endmodule

bind btb2l btb2l_checker #(.IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush),
  .lk_valid    (lk_valid),
  .lk_pc       (lk_pc),
  .upd_valid   (upd_valid),
  .upd_pc      (upd_pc),
  .l1_hit      (l1_hit),
  .l2_hit      (l2_hit),
  .lk_miss     (lk_miss),
  .promote_fire(promote_fire)
);

// File: tb/btb2l_bench.sv
module btb2l_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic [31:0] upd_target = '0;
  logic        upd_taken = 1'b0;
  logic        l1_hit, l2_hit, lk_miss;
  logic [31:0] l1_target, l2_target;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  btb2l u_btb2l (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .lk_valid(lk_valid), .lk_pc(lk_pc),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target), .upd_taken(upd_taken),
    .l1_hit(l1_hit), .l1_target(l1_target),
    .l2_hit(l2_hit), .l2_target(l2_target), .lk_miss(lk_miss)
  );

  // Operation codes and expected outcomes
  localparam logic [1:0] OP_LOOK = 2'd0, OP_TAKEN = 2'd1, OP_NOTTAKEN = 2'd2;
  localparam logic [1:0] EX_MISS = 2'd0, EX_L1 = 2'd1, EX_L2 = 2'd2;

  localparam logic [31:0] PA = 32'h0000_1000, TA = 32'h0000_2000;
  localparam logic [31:0] PB = 32'h0000_3004, TB = 32'h0000_4000, TB2 = 32'h0000_5000;
  localparam logic [31:0] PC = 32'h0000_1004, TC = 32'h0000_6000;  // same index as PB
  localparam logic [31:0] PD = 32'h0000_7008;

  localparam int NVEC = 14;
  localparam logic [67:0] VEC [NVEC] = '{
    {OP_LOOK,     PA, 32'h0, EX_MISS},  // R1 empty
    {OP_TAKEN,    PA, TA,    EX_MISS},  // R5
    {OP_LOOK,     PA, TA,    EX_L1},    // R2 R5
    {OP_TAKEN,    PB, TB,    EX_MISS},
    {OP_TAKEN,    PB, TB2,   EX_MISS},  // R11
    {OP_LOOK,     PB, TB2,   EX_L1},    // R11
    {OP_NOTTAKEN, PA, 32'h0, EX_MISS},  // R7
    {OP_LOOK,     PA, TA,    EX_L2},    // R3 R7
    {OP_LOOK,     PA, TA,    EX_L1},    // R6
    {OP_TAKEN,    PC, TC,    EX_MISS},  // R12
    {OP_NOTTAKEN, PB, 32'h0, EX_MISS},
    {OP_LOOK,     PB, 32'h0, EX_MISS},  // R12 evicted from level two
    {OP_LOOK,     PC, TC,    EX_L1},    // R12
    {OP_LOOK,     PD, 32'h0, EX_MISS}   // R4
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_update(input logic [31:0] pc, input logic [31:0] tgt, input logic taken);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_target = tgt; upd_taken = taken;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic do_lookup(input logic [31:0] pc, input logic [1:0] ex,
                           input logic [31:0] tgt, input string req);
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = pc;
    @(negedge clk);
    lk_valid = 1'b0;
    check(l1_hit == (ex == EX_L1), {req, " l1_hit"}, 32'(l1_hit), 32'(ex == EX_L1));
    if (ex == EX_L1) check(l1_target == tgt, {req, " l1_target"}, l1_target, tgt);
    @(negedge clk);
    check(l2_hit == (ex == EX_L2), {req, " l2_hit"}, 32'(l2_hit), 32'(ex == EX_L2));
    check(lk_miss == (ex == EX_MISS), {req, " lk_miss"}, 32'(lk_miss), 32'(ex == EX_MISS));
    if (ex == EX_L2) check(l2_target == tgt, {req, " l2_target"}, l2_target, tgt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!l1_hit && !l2_hit && !lk_miss, "R1 reset outputs", {l1_hit, l2_hit, lk_miss}, 32'h0);

    for (int v = 0; v < NVEC; v++) begin
      logic [67:0] e;
      e = VEC[v];
      case (e[67:66])
        OP_LOOK:     do_lookup(e[65:34], e[1:0], e[33:2], $sformatf("R1-5 vec%0d", v));
        OP_TAKEN:    do_update(e[65:34], e[33:2], 1'b1);
        default:     do_update(e[65:34], e[33:2], 1'b0);
      endcase
    end

    // R9: lookup and update on the same index in one cycle
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = PA;
    upd_valid = 1'b1; upd_pc = PA; upd_target = 32'h0000_A000; upd_taken = 1'b1;
    @(negedge clk);
    lk_valid = 1'b0; upd_valid = 1'b0;
    check(!l1_hit, "R9 no l1_hit on conflict", 32'(l1_hit), 32'h0);
    @(negedge clk);
    check(lk_miss && !l2_hit, "R9 conflict reports miss", {l2_hit, lk_miss}, 32'h1);
    do_lookup(PA, EX_L1, 32'h0000_A000, "R9 update applied");

    // R10: flush
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    check(!l1_hit && !l2_hit && !lk_miss, "R10 quiet after flush", {l1_hit, l2_hit, lk_miss}, 32'h0);
    do_lookup(PA, EX_MISS, 32'h0, "R10 A cleared");
    do_lookup(PC, EX_MISS, 32'h0, "R10 C cleared");

    // R8: round-robin replacement in level one
    for (int i = 0; i < 65; i++)
      do_update(32'h0010_0000 + 32'(i * 4), 32'h9000_0000 + 32'(i), 1'b1);
    do_lookup(32'h0010_0004, EX_L1, 32'h9000_0001, "R8 second kept");
    do_lookup(32'h0010_0100, EX_L1, 32'h9000_0040, "R8 newest kept");
    do_lookup(32'h0010_0000, EX_L2, 32'h9000_0000, "R8 first evicted");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule